// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is the programming front end of a frequency synthesizer. A host writes 24-bit words over three wires: a serial clock, a data line and a strobe. The block shifts each word in while the strobe is low. When the strobe rises, it decodes the address prefix in the top bits and routes the word to one of four register groups. All three serial lines and the transmit-enable input are sampled on the system clock `clk`, and all edges are detected on that clock. The divider synchronization pulse is a one-`clk` input.

The four groups are:
- **Main-loop group.** Takes effect only on a divider synchronization pulse. This avoids a phase step when the ratio changes.
- **Reference group.** Holds the reference ratio and the two comparison tap selects, which load at once. It also carries the fractional compensation DAC code. That code waits in a temporary register and reaches its output together with the next main-loop commit.
- **Auxiliary / charge-pump group.** Holds the auxiliary ratio, the charge-pump ratio, the lock-output select and the two power-down bits.
- **Transmit group.** Holds the power code, the offset-loop divide-by-M code and five mode bits.

A speed-up flag rises when the main-loop word commits and stays up until the strobe falls. A transmit-group word with its offset-enable bit set arms a synthesizer-enable flag. That flag sets on the following strobe fall and clears on a falling edge of the transmit-enable input.

Top module: `serprog_bank`

## Requirements
- R1: After reset, the outputs hold these values:
  - Main-loop group: main ratio 2048, increment 0, modulus flag 0.
  - Reference group: reference ratio 81, both taps 0, DAC code 80.
  - Auxiliary / charge-pump group: auxiliary ratio 1024, charge-pump ratio 0, lock select 0, both power-enables 0.
  - Transmit group: power code 0, divide-by-M value 6, all mode bits 0.
  - Status: speed-up 0, synthesizer enable 0.
- R2: Shifting and decode:
  - Each rising serial-clock edge seen while the strobe is low shifts the data bit in at the top of a 24-bit register. The first bit sent therefore ends up at bit 0.
  - On a strobe rise, bits 23:22 = 10 select the auxiliary / charge-pump group. Its fields are: auxiliary ratio in bits 21:8, charge-pump ratio in 7:6, lock select in 5:4, main power-enable in bit 3, auxiliary power-enable in bit 2.
- R3: Serial-clock edges seen while the strobe is high leave the shift register unchanged.
- R4: A strobe rise with bits 23:22 = 01 loads, in the next cycle:
  - the reference ratio from bits 21:12;
  - the main tap from bits 11:10;
  - the auxiliary tap from bits 9:8.
  
  The DAC code in bits 7:0 goes only to the temporary register; the DAC output does not change.
- R5: Main-loop word commit:
  - A strobe rise with bits 23:22 = 00 stages a main-loop word: modulus flag in bit 21, increment in 20:18, main ratio in 17:2.
  - The staged word reaches the outputs only in the cycle after a sync pulse that arrives while the strobe is still high.
  - The staged DAC code reaches its output in that same cycle.
- R6: A staged main-loop word is discarded if the strobe falls before a sync pulse arrives.
- R7: Speed-up is set in the cycle a main-loop word commits. It stays set while the strobe stays high and clears one cycle after the strobe is seen low.
- R8: A strobe rise with bits 23:21 = 110 loads the transmit group:
  - power code from bits 20:13;
  - M code from 12:11 (00 gives 6, 01 gives 7, 10 gives 8, 11 gives 9);
  - offset-enable bit 10, dual-select bit 9, digital-mode bit 8, TX-LO buffer bit 7, reference-buffer bit 6.
- R9: The transmit group loads at most once per strobe-high period.
- R10: Synthesizer-enable behaviour:
  - It sets one cycle after the strobe falls, if a transmit word with offset-enable = 1 was loaded in that strobe-high period.
  - A transmit word with offset-enable = 0 does not set it.
  - A falling transmit-enable edge clears it, and this clear takes priority.
  - A rising transmit-enable edge has no effect.
- R11: A word with bits 23:21 = 111 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data |
| ser_stb | input | 1 | Load strobe; low = shift, high = hold/load |
| tx_en | input | 1 | Transmit enable |
| div_sync | input | 1 | Main divider terminal-count pulse |
| frac_mod5 | output | 1 | Fractional modulus select (1 = modulo 5) |
| frac_inc | output | 3 | Fractional increment |
| main_ratio | output | 16 | Main divider ratio |
| ref_ratio | output | 10 | Reference divider ratio |
| main_tap | output | 2 | Main comparison tap select |
| aux_tap | output | 2 | Auxiliary comparison tap select |
| frac_dac | output | 8 | Fractional compensation DAC code |
| aux_ratio | output | 14 | Auxiliary divider ratio |
| cp_ratio | output | 2 | Charge-pump current ratio |
| lock_sel | output | 2 | Lock output select |
| main_pwr | output | 1 | Main loop power enable |
| aux_pwr | output | 1 | Auxiliary loop power enable |
| pwr_code | output | 8 | Output power attenuation code |
| mdiv | output | 4 | Offset-loop divide value, 6 to 9 |
| offs_en | output | 1 | Offset-loop enable bit |
| dual_sel | output | 1 | Dual-mode select bit |
| digital_mode | output | 1 | Digital / analog mode bit |
| txlo_on | output | 1 | TX-LO buffer enable |
| rclk_on | output | 1 | Reference clock buffer enable |
| speedup | output | 1 | Speed-up mode flag |
| syn_en | output | 1 | Offset synthesizer enable |

## Verification
Each check is timed by counting the edge detectors and output registers between a stimulus and the output it affects:

| Stimulus | Output affected | When it is due |
|---|---|---|
| Strobe rise | Reference, auxiliary and transmit fields | At the first `clk` edge that sees the strobe high |
| Sync pulse | Main-loop fields and the DAC output | At the edge that samples the sync pulse |
| Strobe fall | Speed-up clears, synthesizer enable sets | At the edge that first samples the strobe low |
| Transmit-enable edge | Synthesizer enable | At the edge that first samples the new level |

The bench drives every input on the falling edge of `clk` and samples outputs two falling edges after the stimulus. Every registered result has therefore settled before it is read. Before a commit, the bench also samples the outputs that must not move, so that staging and discard are seen at the ports.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam int WORD_W  = 24;
  localparam int RATIO_W = 16;
  localparam int INC_W   = 3;
  localparam int REF_W   = 10;
  localparam int TAP_W   = 2;
  localparam int DAC_W   = 8;
  localparam int AUX_W   = 14;
  localparam int SEL_W   = 2;
  localparam int PWR_W   = 8;
  localparam int MCODE_W = 2;
  localparam int MDIV_W  = 4;
  localparam int MBASE   = 6;

  typedef enum logic [2:0] {W_NONE, W_MAIN, W_REF, W_AUX, W_TX} wsel_t;

  typedef struct packed {
    logic               mod5;
    logic [INC_W-1:0]   inc;
    logic [RATIO_W-1:0] ratio;
  } main_cfg_t;

  typedef struct packed {
    logic [REF_W-1:0] ref_ratio;
    logic [TAP_W-1:0] main_tap;
    logic [TAP_W-1:0] aux_tap;
  } ref_cfg_t;

  typedef struct packed {
    logic [AUX_W-1:0] aux_ratio;
    logic [SEL_W-1:0] cp;
    logic [SEL_W-1:0] lock_sel;
    logic             main_pwr;
    logic             aux_pwr;
  } aux_cfg_t;

  typedef struct packed {
    logic [PWR_W-1:0]   pwr_code;
    logic [MCODE_W-1:0] mcode;
    logic               se;
    logic               tm;
    logic               ad;
    logic               sm1;
    logic               sm2;
  } tx_cfg_t;

  localparam main_cfg_t MAIN_RST = '{mod5: 1'b0, inc: '0, ratio: 16'd2048};
  localparam ref_cfg_t  REF_RST  = '{ref_ratio: 10'd81, main_tap: '0, aux_tap: '0};
  localparam logic [DAC_W-1:0] DAC_RST = 8'd80;
  localparam aux_cfg_t  AUX_RST  = '{aux_ratio: 14'd1024, cp: '0, lock_sel: '0,
                                     main_pwr: 1'b0, aux_pwr: 1'b0};
  localparam tx_cfg_t   TX_RST   = '{pwr_code: '0, mcode: '0, se: 1'b0, tm: 1'b0,
                                     ad: 1'b0, sm1: 1'b0, sm2: 1'b0};

  function automatic wsel_t decode_word(input logic [WORD_W-1:0] w);
    case (w[WORD_W-1 -: 2])
      2'b00:   return W_MAIN;
      2'b01:   return W_REF;
      2'b10:   return W_AUX;
      default: return w[WORD_W-3] ? W_NONE : W_TX;
    endcase
  endfunction
endpackage

// File: rtl/sp_shift.sv
module sp_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdat,
  input  logic         stb,
  output logic [W-1:0] word,
  output logic         stb_rise,
  output logic         stb_fall
);
  logic         sclk_q, stb_q;
  logic         shift_en;
  logic [W-1:0] word_d;

  always_comb begin
    shift_en = !stb && sclk && !sclk_q;
    word_d   = shift_en ? {sdat, word[W-1:1]} : word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word   <= '0;
      sclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      sclk_q <= sclk;
      stb_q  <= stb;
      if (shift_en) word <= word_d;
    end
  end

  assign stb_rise = stb && !stb_q;
  assign stb_fall = !stb && stb_q;
endmodule

// File: rtl/sp_regs.sv
module sp_regs
  import serprog_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WORD_W-1:0]       word,
  input  logic                    stb,
  input  logic                    stb_rise,
  input  logic                    div_sync,
  output main_cfg_t               main_cfg,
  output ref_cfg_t                ref_cfg,
  output logic [DAC_W-1:0]        dac,
  output aux_cfg_t                aux_cfg,
  output tx_cfg_t                 tx_cfg,
  output logic                    speedup,
  output logic                    d_done
);
  wsel_t            wsel;
  logic             ld_main, ld_ref, ld_aux, ld_tx, a_commit;
  logic             a_pend, a_pend_d, speedup_d, d_done_d;
  main_cfg_t        main_stage, main_stage_d;
  logic [DAC_W-1:0] dac_tmp, dac_tmp_d;
  ref_cfg_t         ref_d;
  aux_cfg_t         aux_d;
  tx_cfg_t          tx_d;

  always_comb begin
    wsel     = decode_word(word);
    ld_main  = stb_rise && (wsel == W_MAIN);
    ld_ref   = stb_rise && (wsel == W_REF);
    ld_aux   = stb_rise && (wsel == W_AUX);
    // one-shot guard: at most one transmit load per strobe-high period
    ld_tx    = stb && (wsel == W_TX) && !d_done;
    a_commit = a_pend && stb && div_sync;

    main_stage_d = '{mod5: word[21], inc: word[20:18], ratio: word[17:2]};
    ref_d        = '{ref_ratio: word[21:12], main_tap: word[11:10], aux_tap: word[9:8]};
    dac_tmp_d    = word[7:0];
    aux_d        = '{aux_ratio: word[21:8], cp: word[7:6], lock_sel: word[5:4],
                     main_pwr: word[3], aux_pwr: word[2]};
    tx_d         = '{pwr_code: word[20:13], mcode: word[12:11], se: word[10],
                     tm: word[9], ad: word[8], sm1: word[7], sm2: word[6]};

    if (!stb)          a_pend_d = 1'b0;
    else if (ld_main)  a_pend_d = 1'b1;
    else if (a_commit) a_pend_d = 1'b0;
    else               a_pend_d = a_pend;

    speedup_d = stb && (speedup || a_commit);
    d_done_d  = stb && (d_done || ld_tx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_stage <= MAIN_RST;
      main_cfg   <= MAIN_RST;
      ref_cfg    <= REF_RST;
      dac_tmp    <= DAC_RST;
      dac        <= DAC_RST;
      aux_cfg    <= AUX_RST;
      tx_cfg     <= TX_RST;
      a_pend     <= 1'b0;
      speedup    <= 1'b0;
      d_done     <= 1'b0;
    end else begin
      if (ld_main)  main_stage <= main_stage_d;
      if (a_commit) main_cfg   <= main_stage;
      if (ld_ref)   ref_cfg    <= ref_d;
      if (ld_ref)   dac_tmp    <= dac_tmp_d;
      if (a_commit) dac        <= dac_tmp;
      if (ld_aux)   aux_cfg    <= aux_d;
      if (ld_tx)    tx_cfg     <= tx_d;
      a_pend  <= a_pend_d;
      speedup <= speedup_d;
      d_done  <= d_done_d;
    end
  end
endmodule

// File: rtl/sp_txen.sv
module sp_txen (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic stb_fall,
  input  logic arm,
  output logic syn_en
);
  logic txen_q, tx_fall, syn_d;

  always_comb begin
    tx_fall = !tx_en && txen_q;
    if (tx_fall)               syn_d = 1'b0;
    else if (stb_fall && arm)  syn_d = 1'b1;
    else                       syn_d = syn_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txen_q <= 1'b0;
      syn_en <= 1'b0;
    end else begin
      txen_q <= tx_en;
      syn_en <= syn_d;
    end
  end
endmodule

// File: rtl/serprog_bank.sv
module serprog_bank
  import serprog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_stb,
  input  logic               tx_en,
  input  logic               div_sync,
  output logic               frac_mod5,
  output logic [INC_W-1:0]   frac_inc,
  output logic [RATIO_W-1:0] main_ratio,
  output logic [REF_W-1:0]   ref_ratio,
  output logic [TAP_W-1:0]   main_tap,
  output logic [TAP_W-1:0]   aux_tap,
  output logic [DAC_W-1:0]   frac_dac,
  output logic [AUX_W-1:0]   aux_ratio,
  output logic [SEL_W-1:0]   cp_ratio,
  output logic [SEL_W-1:0]   lock_sel,
  output logic               main_pwr,
  output logic               aux_pwr,
  output logic [PWR_W-1:0]   pwr_code,
  output logic [MDIV_W-1:0]  mdiv,
  output logic               offs_en,
  output logic               dual_sel,
  output logic               digital_mode,
  output logic               txlo_on,
  output logic               rclk_on,
  output logic               speedup,
  output logic               syn_en
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;
  logic [WORD_W-1:0]      sr_word;
  logic                   stb_rise, stb_fall, d_done;
  main_cfg_t              main_cfg;
  ref_cfg_t               ref_cfg;
  aux_cfg_t               aux_cfg;
  tx_cfg_t                tx_cfg;

  // asynchronous assertion, synchronous release
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe[g] <= 1'b0;
        else        rst_pipe[g] <= (g == 0) ? 1'b1 : rst_pipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  sp_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_q_n), .sclk(ser_clk), .sdat(ser_data), .stb(ser_stb),
    .word(sr_word), .stb_rise(stb_rise), .stb_fall(stb_fall)
  );

  sp_regs u_regs (
    .clk(clk), .rst_n(rst_q_n), .word(sr_word), .stb(ser_stb), .stb_rise(stb_rise),
    .div_sync(div_sync), .main_cfg(main_cfg), .ref_cfg(ref_cfg), .dac(frac_dac),
    .aux_cfg(aux_cfg), .tx_cfg(tx_cfg), .speedup(speedup), .d_done(d_done)
  );

  sp_txen u_txen (
    .clk(clk), .rst_n(rst_q_n), .tx_en(tx_en), .stb_fall(stb_fall),
    .arm(d_done && tx_cfg.se), .syn_en(syn_en)
  );

  always_comb begin
    frac_mod5    = main_cfg.mod5;
    frac_inc     = main_cfg.inc;
    main_ratio   = main_cfg.ratio;
    ref_ratio    = ref_cfg.ref_ratio;
    main_tap     = ref_cfg.main_tap;
    aux_tap      = ref_cfg.aux_tap;
    aux_ratio    = aux_cfg.aux_ratio;
    cp_ratio     = aux_cfg.cp;
    lock_sel     = aux_cfg.lock_sel;
    main_pwr     = aux_cfg.main_pwr;
    aux_pwr      = aux_cfg.aux_pwr;
    pwr_code     = tx_cfg.pwr_code;
    mdiv         = MDIV_W'(MBASE) + {{(MDIV_W-MCODE_W){1'b0}}, tx_cfg.mcode};
    offs_en      = tx_cfg.se;
    dual_sel     = tx_cfg.tm;
    digital_mode = tx_cfg.ad;
    txlo_on      = tx_cfg.sm1;
    rclk_on      = tx_cfg.sm2;
  end
endmodule

// File: rtl/serprog_bank_checks.sv
module serprog_bank_checks
  import serprog_pkg::*;
(
  input logic               clk,
  input logic               rst_q_n,
  input logic               ser_stb,
  input logic               div_sync,
  input logic               tx_en,
  input logic [WORD_W-1:0]  sr_word,
  input logic [DAC_W-1:0]   frac_dac,
  input logic [RATIO_W-1:0] main_ratio,
  input logic               speedup,
  input logic               syn_en
);
  assert_hold_shift_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(ser_stb) |-> $stable(sr_word));

  assert_dac_with_sync_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(frac_dac) |-> ($past(div_sync) && $past(ser_stb)));

  assert_ratio_with_sync_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(main_ratio) |-> ($past(div_sync) && $past(ser_stb)));

  assert_speedup_drop_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ser_stb |=> !speedup);

  assert_speedup_rise_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(speedup) |-> $past(div_sync));

  assert_txen_clear_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(tx_en) |=> !syn_en);

  assert_syn_set_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(syn_en) |-> (!$past(ser_stb) && $past(ser_stb, 2)));
endmodule

bind serprog_bank serprog_bank_checks u_checks (
  .clk(clk), .rst_q_n(rst_q_n), .ser_stb(ser_stb), .div_sync(div_sync),
  .tx_en(tx_en), .sr_word(sr_word), .frac_dac(frac_dac),
  .main_ratio(main_ratio), .speedup(speedup), .syn_en(syn_en)
);

// File: tb/serprog_bank_tb.sv
module serprog_bank_tb;
  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_data, ser_stb, tx_en, div_sync;
  logic        frac_mod5, main_pwr, aux_pwr, offs_en, dual_sel, digital_mode;
  logic        txlo_on, rclk_on, speedup, syn_en;
  logic [2:0]  frac_inc;
  logic [15:0] main_ratio;
  logic [9:0]  ref_ratio;
  logic [1:0]  main_tap, aux_tap, cp_ratio, lock_sel;
  logic [7:0]  frac_dac, pwr_code;
  logic [13:0] aux_ratio;
  logic [3:0]  mdiv;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  serprog_bank u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_raw(input logic [23:0] w);
    for (int i = 0; i < 24; i++) begin
      ser_data = w[i];
      wait_n(1);
      ser_clk = 1'b1;
      wait_n(2);
      ser_clk = 1'b0;
      wait_n(1);
    end
  endtask

  task automatic send(input logic [23:0] w);
    ser_stb = 1'b0;
    wait_n(1);
    shift_raw(w);
    ser_stb = 1'b1;
    wait_n(2);
  endtask

  task automatic stb_low();
    ser_stb = 1'b0;
    wait_n(2);
  endtask

  task automatic sync_pulse();
    div_sync = 1'b1;
    wait_n(1);
    div_sync = 1'b0;
    wait_n(1);
  endtask

  function automatic logic [23:0] w_main(input logic m5, input logic [2:0] inc, input logic [15:0] r);
    return {2'b00, m5, inc, r, 2'b00};
  endfunction
  function automatic logic [23:0] w_ref(input logic [9:0] r, input logic [1:0] mt, input logic [1:0] at,
                                        input logic [7:0] d);
    return {2'b01, r, mt, at, d};
  endfunction
  function automatic logic [23:0] w_aux(input logic [13:0] a, input logic [1:0] cp, input logic [1:0] ld,
                                        input logic p1, input logic p2);
    return {2'b10, a, cp, ld, p1, p2, 2'b00};
  endfunction
  function automatic logic [23:0] w_tx(input logic [7:0] pc, input logic [1:0] m, input logic [4:0] bits);
    return {3'b110, pc, m, bits, 6'b0};
  endfunction

  initial begin
    wait_n(100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_stb = 1'b0;
    tx_en = 1'b0; div_sync = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);

    // R1 reset state
    check("R1 main_ratio", main_ratio, 2048);
    check("R1 frac_inc", frac_inc, 0);
    check("R1 ref_ratio", ref_ratio, 81);
    check("R1 frac_dac", frac_dac, 80);
    check("R1 aux_ratio", aux_ratio, 1024);
    check("R1 mdiv", mdiv, 6);
    check("R1 pwr", {main_pwr, aux_pwr, offs_en, txlo_on, rclk_on}, 0);
    check("R1 speedup", speedup, 0);
    check("R1 syn_en", syn_en, 0);

    // R2 auxiliary group sweep
    for (int k = 0; k < 4; k++) begin
      send(w_aux(14'(1000 + 37 * k), 2'(3 - k), 2'(k), k[0], k[1]));
      check("R2 aux_ratio", aux_ratio, 1000 + 37 * k);
      check("R2 cp_ratio", cp_ratio, 3 - k);
      check("R2 lock_sel", lock_sel, k);
      check("R2 power bits", {main_pwr, aux_pwr}, {k[0], k[1]});
      stb_low();
    end

    // R3 shifting frozen while strobe high
    send(w_aux(14'd4321, 2'd1, 2'd2, 1'b1, 1'b0));
    shift_raw(w_aux(14'd99, 2'd0, 2'd0, 1'b0, 1'b1));
    stb_low();
    ser_stb = 1'b1;
    wait_n(2);
    check("R3 aux_ratio after clocks while high", aux_ratio, 4321);
    check("R3 lock_sel", lock_sel, 2);
    stb_low();

    // R4 reference group, DAC staged
    send(w_ref(10'd300, 2'd2, 2'd1, 8'h5A));
    check("R4 ref_ratio", ref_ratio, 300);
    check("R4 taps", {main_tap, aux_tap}, {2'd2, 2'd1});
    check("R4 dac held", frac_dac, 80);
    stb_low();

    // R5/R7 main-loop commit on sync
    send(w_main(1'b1, 3'd3, 16'd5000));
    wait_n(3);
    check("R5 ratio before sync", main_ratio, 2048);
    check("R5 dac before sync", frac_dac, 80);
    check("R7 speedup before sync", speedup, 0);
    sync_pulse();
    check("R5 ratio", main_ratio, 5000);
    check("R5 mod5/inc", {frac_mod5, frac_inc}, {1'b1, 3'd3});
    check("R5 dac with commit", frac_dac, 8'h5A);
    check("R7 speedup set", speedup, 1);
    wait_n(5);
    check("R7 speedup held", speedup, 1);
    stb_low();
    check("R7 speedup cleared", speedup, 0);

    // R5 sweep
    for (int k = 0; k < 8; k++) begin
      send(w_main(k[0], 3'(k), 16'(512 + 1111 * k)));
      sync_pulse();
      check("R5 sweep ratio", main_ratio, 512 + 1111 * k);
      check("R5 sweep inc", {frac_mod5, frac_inc}, {k[0], 3'(k)});
      stb_low();
    end

    // R6 staged word discarded when strobe falls first
    send(w_main(1'b0, 3'd5, 16'd777));
    stb_low();
    sync_pulse();
    check("R6 ratio kept", main_ratio, 512 + 1111 * 7);
    check("R6 speedup", speedup, 0);

    // R8 transmit group sweep
    for (int m = 0; m < 4; m++) begin
      send(w_tx(8'(60 * m + 3), 2'(m), {1'b0, 2'(m), 2'(~m)}));
      check("R8 mdiv", mdiv, 6 + m);
      check("R8 pwr_code", pwr_code, 60 * m + 3);
      check("R8 mode bits", {offs_en, dual_sel, digital_mode, txlo_on, rclk_on},
            {1'b0, 2'(m), 2'(~m)});
      stb_low();
      check("R10 no set when enable bit 0", syn_en, 0);
    end

    // R9 transmit group loads once; stays stable through a long high period
    send(w_tx(8'd200, 2'd2, 5'b01011));
    wait_n(10);
    check("R9 pwr_code stable", pwr_code, 200);
    check("R9 mdiv stable", mdiv, 8);
    stb_low();

    // R11 unused address
    send({3'b111, 21'h1FFFFF});
    check("R11 pwr_code unchanged", pwr_code, 200);
    check("R11 aux unchanged", aux_ratio, 4321);
    check("R11 ref unchanged", ref_ratio, 300);
    check("R11 ratio unchanged", main_ratio, 512 + 1111 * 7);
    stb_low();

    // R10 synthesizer enable
    send(w_tx(8'd1, 2'd0, 5'b10000));
    check("R10 not set while strobe high", syn_en, 0);
    stb_low();
    check("R10 set on strobe fall", syn_en, 1);
    tx_en = 1'b1;
    wait_n(2);
    check("R10 rising tx_en no effect", syn_en, 1);
    tx_en = 1'b0;
    wait_n(2);
    check("R10 falling tx_en clears", syn_en, 0);
    send(w_tx(8'd1, 2'd0, 5'b10000));
    stb_low();
    check("R10 set again", syn_en, 1);
    tx_en = 1'b1;
    wait_n(2);
    tx_en = 1'b0;
    wait_n(2);
    check("R10 cleared again", syn_en, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule